// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block produces one or two rectangular outputs whose period and high time software sets through a small word-addressed register file. Each channel has three registers. The control register holds a 6-bit prescaler value and a shutdown-style bit. The duty register holds a 10-bit high-time count and a full-on flag. The period register holds a 10-bit period count. Each channel has a per-channel prescale counter that divides the input clock by (prescale + 1). A period counter steps on each prescaled tick. The output is high while the period counter is below the duty count.

Programmed values go into shadow registers. A channel copies them into its working copy only when it starts or when a period wraps, so a reprogram never leaves a partial period. Each channel has its own enable input. The shutdown bit selects how a channel stops. With the bit clear, the channel finishes the running period before it goes idle. With the bit set, it goes idle on the next clock edge.

Top module: `pwm_unit`

## Requirements
- R1: After reset every output is low and every register reads back as zero.
- R2: The bus uses word addresses. Word 0 is control: prescale in bits 5:0, shutdown bit in bit 6. Word 1 is duty: count in bits 9:0, full-on flag in bit 10. Word 2 is period: count in bits 9:0. Reads return the stored fields with all other bits zero. Word 3 of a channel reads zero and ignores writes.
- R3: The second channel occupies word addresses 4 to 6 (byte offset 0x10). It runs independently of the first channel.
- R4: A running channel repeats a period of (prescale+1)*(period+1) clock cycles. It is high for the first (prescale+1)*duty cycles of each period. The first period begins in the cycle after the enable is sampled high.
- R5: With the full-on flag set, the output stays high for the whole period whatever the duty count.
- R6: A duty count of 0 with the flag clear gives a constant low output. A duty count above the period count gives a constant high output.
- R7: A write to prescale, duty or period changes the output only from the next period boundary on. A write made in the last cycle of a period waits one more full period.
- R8: While a channel is idle and its enable is low, its output is low and its counters stay cleared. A later enable starts from the beginning of a period.
- R9: If the enable drops while the shutdown bit is clear, the channel completes the current period with the same waveform and then goes idle.
- R10: If the enable is low while the shutdown bit is set, the output is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NUM_CH | Per-channel run enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pwm_out | output | NUM_CH | Modulated outputs |

## Verification
The hardest case to reach is a register write that lands in the last cycle of a period, or while a graceful stop is draining. The edge that commits the write is the same edge that reloads the working copy, so the update has to wait a whole extra period. The bench keeps a cycle model of every channel and compares both outputs in every cycle. It also sends random writes at random points inside running periods, with short periods and small prescalers, so writes often fall on the boundary cycle and on drains, and both stop modes get mixed in.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int BUS_W    = 32;
  localparam int PRE_W    = 6;
  localparam int CNT_W    = 10;
  localparam int REG_SEL_W = 2;
  localparam logic [REG_SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [REG_SEL_W-1:0] SEL_DUTY = 2'd1;
  localparam logic [REG_SEL_W-1:0] SEL_PER  = 2'd2;
  localparam int SD_BIT   = PRE_W;
  localparam int FULL_BIT = CNT_W;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             sd;
    logic [CNT_W-1:0] dc;
    logic             full;
    logic [CNT_W-1:0] pv;
  } ch_cfg_t;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] dc;
    logic             full;
    logic [CNT_W-1:0] pv;
  } ch_act_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [BUS_W-1:0]          bus_wdata,
  output logic [BUS_W-1:0]          bus_rdata,
  output ch_cfg_t [NUM_CH-1:0]      cfg_o
);
  localparam int CH_IDX_W = ADDR_W - REG_SEL_W;

  logic [CH_IDX_W-1:0]  ch_idx;
  logic [REG_SEL_W-1:0] rsel;
  logic [BUS_W-1:FULL_BIT+1] wdata_unused;

  assign ch_idx       = bus_addr[ADDR_W-1:REG_SEL_W];
  assign rsel         = bus_addr[REG_SEL_W-1:0];
  assign wdata_unused = bus_wdata[BUS_W-1:FULL_BIT+1];

  ch_cfg_t [NUM_CH-1:0] cfg_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic    hit;
    ch_cfg_t cfg_d;

    assign hit = bus_sel && bus_wr && (ch_idx == CH_IDX_W'(c));

    always_comb begin
      cfg_d = cfg_q[c];
      case (rsel)
        SEL_CTRL: begin
          cfg_d.pre = bus_wdata[PRE_W-1:0];
          cfg_d.sd  = bus_wdata[SD_BIT];
        end
        SEL_DUTY: begin
          cfg_d.dc   = bus_wdata[CNT_W-1:0];
          cfg_d.full = bus_wdata[FULL_BIT];
        end
        SEL_PER: begin
          cfg_d.pv = bus_wdata[CNT_W-1:0];
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[c] <= '0;
      end else if (hit) begin
        cfg_q[c] <= cfg_d;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == CH_IDX_W'(c)) begin
          case (rsel)
            SEL_CTRL: bus_rdata = BUS_W'({cfg_q[c].sd, cfg_q[c].pre});
            SEL_DUTY: bus_rdata = BUS_W'({cfg_q[c].full, cfg_q[c].dc});
            SEL_PER:  bus_rdata = BUS_W'(cfg_q[c].pv);
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         wrap;

  assign wrap = (cnt_q == limit);
  assign tick = wrap;

  always_comb begin
    if (clr || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_period.sv
module pwm_period
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  ch_cfg_t          prog,
  output ch_act_t          act_o,
  output logic             run_o,
  output logic             bound_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clr_o,
  output logic             pwm_o
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ld;
  logic             bound;
  ch_act_t          act_q, act_d;

  assign bound = run_q && tick && (cnt_q == act_q.pv);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    ld    = 1'b0;
    if (!run_q) begin
      cnt_d = '0;
      if (en) begin
        run_d = 1'b1;
        ld    = 1'b1;
      end
    end else if (!en && prog.sd) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (bound) begin
      cnt_d = '0;
      if (en) begin
        ld = 1'b1;
      end else begin
        run_d = 1'b0;
      end
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    act_d.pre  = prog.pre;
    act_d.dc   = prog.dc;
    act_d.full = prog.full;
    act_d.pv   = prog.pv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (ld) begin
      act_q <= act_d;
    end
  end

  assign clr_o   = !run_q || !run_d;
  assign pwm_o   = run_q && (act_q.full || (cnt_q < act_q.dc));
  assign act_o   = act_q;
  assign run_o   = run_q;
  assign bound_o = bound;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  ch_en,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic [NUM_CH-1:0]  pwm_out
);
  ch_cfg_t [NUM_CH-1:0] ch_cfg;
  ch_act_t [NUM_CH-1:0] ch_act;

  logic [NUM_CH-1:0]            ch_run;
  logic [NUM_CH-1:0]            ch_bound;
  logic [NUM_CH-1:0]            ch_full;
  logic [NUM_CH-1:0]            ch_sd;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_dc;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_pv;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;

  pwm_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_o     (ch_cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic tick;
    logic clr;

    pwm_prescale #(
      .W (PRE_W)
    ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .limit (ch_act[c].pre),
      .tick  (tick)
    );

    pwm_period u_per (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ch_en[c]),
      .tick    (tick),
      .prog    (ch_cfg[c]),
      .act_o   (ch_act[c]),
      .run_o   (ch_run[c]),
      .bound_o (ch_bound[c]),
      .cnt_o   (ch_cnt[c]),
      .clr_o   (clr),
      .pwm_o   (pwm_out[c])
    );

    assign ch_full[c] = ch_act[c].full;
    assign ch_dc[c]   = ch_act[c].dc;
    assign ch_pv[c]   = ch_act[c].pv;
    assign ch_sd[c]   = ch_cfg[c].sd;
  end
endmodule

// File: rtl/pwm_unit_chk.sv
module pwm_unit_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_CH-1:0]               ch_en,
  input logic [NUM_CH-1:0]               pwm_out,
  input logic [NUM_CH-1:0]               ch_run,
  input logic [NUM_CH-1:0]               ch_bound,
  input logic [NUM_CH-1:0]               ch_full,
  input logic [NUM_CH-1:0]               ch_sd,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_dc,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_pv,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_cnt
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[i] |-> (ch_cnt[i] <= ch_pv[i])); // R4

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[i] && ch_full[i]) |-> pwm_out[i]); // R5

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[i] && !ch_full[i] && (ch_dc[i] == '0)) |-> !pwm_out[i]); // R6

    AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[i] && !ch_bound[i]) |=> ($stable(ch_pv[i]) && $stable(ch_dc[i]) && $stable(ch_full[i]))); // R7

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[i] |-> !pwm_out[i]); // R8

    AST_DRAIN_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[i] && !ch_bound[i] && !ch_sd[i]) |=> ch_run[i]); // R9

    AST_STOP_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[i] && !ch_en[i] && ch_sd[i]) |=> (!ch_run[i] && !pwm_out[i])); // R10
  end
endmodule

bind pwm_unit pwm_unit_chk #(
  .NUM_CH (NUM_CH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_en    (ch_en),
  .pwm_out  (pwm_out),
  .ch_run   (ch_run),
  .ch_bound (ch_bound),
  .ch_full  (ch_full),
  .ch_sd    (ch_sd),
  .ch_dc    (ch_dc),
  .ch_pv    (ch_pv),
  .ch_cnt   (ch_cnt)
);

// File: tb/sim_pwm_unit.sv
module sim_pwm_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [1:0]  ch_en;
  logic        bus_sel;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  pwm_unit #(.NUM_CH(2), .ADDR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int n_run;
  int n_fail;
  bit done;
  string phase;

  // bench model of each channel
  bit       m_run [2];
  int       m_t   [2];
  int       a_pre [2], a_pv [2], a_dc [2];
  bit       a_full[2];
  int       p_pre [2], p_pv [2], p_dc [2];
  bit       p_sd  [2], p_full[2];
  logic [1:0] en_drv;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_out(input int c);
    return m_run[c] && (a_full[c] || ((m_t[c] / (a_pre[c] + 1)) < a_dc[c]));
  endfunction

  task automatic model_edge(input int c);
    int per;
    per = (a_pv[c] + 1) * (a_pre[c] + 1);
    if (!m_run[c]) begin
      if (en_drv[c]) begin
        m_run[c] = 1; m_t[c] = 0;
        a_pre[c] = p_pre[c]; a_pv[c] = p_pv[c]; a_dc[c] = p_dc[c]; a_full[c] = p_full[c];
      end
    end else if (!en_drv[c] && p_sd[c]) begin
      m_run[c] = 0; m_t[c] = 0;
    end else if (m_t[c] == per - 1) begin
      m_t[c] = 0;
      if (en_drv[c]) begin
        a_pre[c] = p_pre[c]; a_pv[c] = p_pv[c]; a_dc[c] = p_dc[c]; a_full[c] = p_full[c];
      end else begin
        m_run[c] = 0;
      end
    end else begin
      m_t[c]++;
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [31:0] d);
    int c;
    c = a[2];
    case (a[1:0])
      2'd0: begin p_pre[c] = int'(d[5:0]); p_sd[c] = d[6]; end
      2'd1: begin p_dc[c] = int'(d[9:0]); p_full[c] = d[10]; end
      2'd2: p_pv[c] = int'(d[9:0]);
      default: ;
    endcase
  endtask

  function automatic int rd_exp(input logic [2:0] a);
    int c;
    c = a[2];
    case (a[1:0])
      2'd0: return p_pre[c] | (int'(p_sd[c]) << 6);
      2'd1: return p_dc[c] | (int'(p_full[c]) << 10);
      2'd2: return p_pv[c];
      default: return 0;
    endcase
  endfunction

  // one clock cycle: compare outputs, drive inputs, advance the model
  task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] d);
    for (int c = 0; c < 2; c++) begin
      bit e;
      e = exp_out(c);
      chk(pwm_out[c] === e, phase, int'(pwm_out[c]), int'(e));
    end
    ch_en = en_drv; bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
    for (int c = 0; c < 2; c++) model_edge(c);
    if (wr) model_write(a, d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 3'd0, 32'd0);
  endtask

  task automatic wr(input int c, input int r, input logic [31:0] d);
    cyc(1, {c[0], r[1:0]}, d);
  endtask

  task automatic rd_chk(input logic [2:0] a, input string req);
    int e;
    e = rd_exp(a);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata == 32'(e), req, int'(bus_rdata), e);
    bus_sel = 1'b0;
  endtask

  task automatic setup(input int c, input int pre, input bit sd, input int dc, input bit full, input int pv);
    wr(c, 0, 32'(pre) | (32'(sd) << 6));
    wr(c, 1, 32'(dc) | (32'(full) << 10));
    wr(c, 2, 32'(pv));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    for (int c = 0; c < 2; c++) begin
      m_run[c] = 0; m_t[c] = 0; a_pre[c] = 0; a_pv[c] = 0; a_dc[c] = 0; a_full[c] = 0;
      p_pre[c] = 0; p_pv[c] = 0; p_dc[c] = 0; p_sd[c] = 0; p_full[c] = 0;
    end
    en_drv = 2'b00; ch_en = 2'b00;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pwm_out == 2'b00, "R1 out", int'(pwm_out), 0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R1 regs");
    phase = "R1 idle";
    idle(4);

    // R2 / R3: field masks and second channel mapping
    phase = "R2 idle";
    for (int a = 0; a < 8; a++) begin
      cyc(1, 3'(a), 32'hFFFF_FFFF);
      rd_chk(3'(a), (a >= 4) ? "R3 readback" : "R2 readback");
    end
    wr(1, 0, 32'h0000_0015);
    rd_chk(3'd4, "R3 ch1 ctrl");
    rd_chk(3'd0, "R3 ch0 untouched");
    wr(0, 1, 32'h0000_0003);
    rd_chk(3'd1, "R2 duty");
    rd_chk(3'd5, "R3 ch1 duty untouched");

    // R4 basic waveform, both channels with different settings
    setup(0, 2, 0, 2, 0, 4);
    setup(1, 0, 0, 3, 0, 6);
    phase = "R4 waveform";
    en_drv = 2'b11;
    idle(60);

    // R5 full-on flag
    phase = "R5 full";
    wr(0, 1, 32'h0000_0401);
    idle(40);

    // R6 zero duty and duty beyond period
    phase = "R6 dc zero";
    wr(0, 1, 32'd0);
    idle(35);
    phase = "R6 dc large";
    wr(0, 1, 32'd5);
    wr(1, 1, 32'd1023);
    idle(35);

    // R7 mid-period reprogram, including writes in the last cycle of a period
    phase = "R7 update";
    setup(0, 1, 0, 1, 0, 2);
    idle(13);
    wr(0, 2, 32'd5);
    wr(0, 0, 32'd0);
    idle(20);
    for (int k = 0; k < 8; k++) begin
      wr(0, 1, 32'(k % 7));
      idle(k);
    end
    idle(20);

    // R9 graceful stop
    phase = "R9 drain";
    setup(0, 1, 0, 3, 0, 7);
    idle(20);
    en_drv[0] = 1'b0;
    idle(25);
    chk(pwm_out[0] == 1'b0, "R9 stopped", int'(pwm_out[0]), 0);

    // R8 idle with full flag set keeps output low, then restart at period start
    phase = "R8 idle";
    wr(0, 1, 32'h0000_0400);
    idle(30);
    en_drv[0] = 1'b1;
    idle(1);
    chk(pwm_out[0] == 1'b1, "R8 restart high", int'(pwm_out[0]), 1);
    idle(20);

    // R10 immediate stop
    phase = "R10 stop";
    setup(0, 3, 1, 4, 0, 9);
    idle(17);
    en_drv[0] = 1'b0;
    idle(1);
    chk(pwm_out[0] == 1'b0, "R10 low next cycle", int'(pwm_out[0]), 0);
    idle(10);

    // R4 extremes: largest prescale and largest period count
    phase = "R4 extremes";
    setup(0, 63, 0, 1, 0, 1);
    setup(1, 0, 0, 512, 0, 1023);
    en_drv = 2'b11;
    idle(1100);
    en_drv = 2'b00;
    idle(1100);

    // random mix of all modes, fixed seed
    phase = "R7 R9 R10 random";
    void'($urandom(32'h5eed_0042));
    for (int it = 0; it < 30; it++) begin
      for (int c = 0; c < 2; c++) begin
        int pv;
        pv = $urandom_range(0, 12);
        setup(c, $urandom_range(0, 4), bit'($urandom_range(0, 1)), $urandom_range(0, pv + 2),
              ($urandom_range(0, 4) == 0), pv);
      end
      en_drv = 2'($urandom_range(1, 3));
      for (int k = 0; k < 4; k++) begin
        idle($urandom_range(5, 40));
        wr($urandom_range(0, 1), $urandom_range(0, 3), $urandom);
      end
      en_drv = 2'($urandom_range(0, 3));
      idle($urandom_range(5, 40));
      en_drv = 2'b00;
      idle(70);
      rd_chk(3'($urandom_range(0, 7)), "R2 random readback");
    end

    summary();
    $finish;
  end
endmodule